// File: doc/BRIEF.md
# Strobed Parallel Register Port with Route Table

This block is the device-side end of an 8-bit parallel bus that a host toggles by software. Bit 7 is a strobe, and only its rising edge counts. The seven bits beneath it carry a payload, and bit 6 of that payload selects its meaning. With bit 6 set, the payload is an address, and the register index is the payload minus 0x40. With bit 6 clear, the low six bits are a value written to the most recently latched address. The host shows each phase first with the strobe low and then with it high. The bus is taken to be synchronous to the block clock.

For reads, the block continuously returns the register at the current address on an 8-bit upper byte. The top bit of that byte mirrors the reserved interrupt pin. The remaining data bits are masked to a parameterised width: 7 bits by default, or 5 in the narrow variant.

Four consecutive register indices form a routing port. Each destination has exactly one source, and one source may feed any number of destinations. A route is committed only when the last of the four registers (source low) is written.

Top module: `strobed_reg_port`

## Requirements
- R1: After reset, all registers read 0, `upper_byte` is 0 while `irq_line` is low, and every route lookup returns 0.
- R2: A phase is taken only on a 0-to-1 change of `host_bus[7]`. A payload shown with the strobe low, or changed while the strobe stays high, has no effect.
- R3: A latched payload of 0x40..0x7F sets the current address to payload-0x40. Two cycles after that strobe edge, `upper_byte[6:0]` shows that register.
- R4: A latched payload of 0x00..0x3F writes its 6 bits to the current address. Repeated value phases keep writing the same address.
- R5: A value phase that arrives before any address phase since reset is ignored.
- R6: `upper_byte[7]` is `irq_line` delayed by one clock. `upper_byte[6:0]` is the 6-bit register value ANDed with a mask of READ_MASK_BITS ones (default 7).
- R7: Indices at or above NUM_REGS (default 56) read as 0, and writes to them are ignored.
- R8: The route registers sit at ROUTE_BASE (default 0x30) in this order: destination high, destination low, source high, source low. A write to the source-low index commits one route. The entry at destination id {dst_hi[2:0], dst_lo[4:0]} is loaded with source id {src_hi[2:0], src_lo[4:0]}. Each id is 8 bits, with the high part in bits 7:5.
- R9: Writes to the destination-high, destination-low or source-high registers alone leave the route table unchanged.
- R10: One source may feed several destinations. A new commit to a destination replaces only that destination's source.
- R11: `route_src` shows, combinationally, the table entry addressed by `route_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| host_bus | input | 8 | Bit 7 strobe, bits 6:0 address or value payload |
| irq_line | input | 1 | Reserved interrupt pin, mirrored on the read byte |
| upper_byte | output | 8 | Read return: interrupt bit plus masked register value |
| route_sel | input | 8 | Destination id to look up |
| route_src | output | 8 | Source id routed to that destination |

## Verification
The bench first sends a value before any address, to tell a correctly ignored write from one that lands at index 0. It then sends normal address/value pairs at low, high and top-of-range indices, and several values to a single address, to tell "last address" from "last pair". Strobe-low payloads and payloads changed while the strobe is held high separate edge detection from level sampling. The route sequences check field masking, confirm there is no commit before source low, show one source feeding two destinations, and show that overwriting one destination leaves the other intact.

// File: rtl/nbr_pkg.sv
package nbr_pkg;
    localparam int VAL_W = 6;
    localparam int IDX_W = 6;
    localparam int ID_W  = 8;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_ADDR = 2'd1,
        EV_DATA = 2'd2
    } ev_kind_t;

    typedef struct packed {
        ev_kind_t           kind;
        logic [VAL_W-1:0]   payload;
    } bus_ev_t;

    function automatic logic [ID_W-1:0] make_id(input logic [VAL_W-1:0] hi,
                                                input logic [VAL_W-1:0] lo);
        return {hi[2:0], lo[4:0]};
    endfunction
endpackage

// File: rtl/nbr_strobe_decode.sv
module nbr_strobe_decode
    import nbr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [7:0]    bus_in,
    output bus_ev_t       ev
);
    logic strobe_prev_q;
    logic rise;

    always_ff @(posedge clk) begin
        if (rst) strobe_prev_q <= 1'b0;
        else     strobe_prev_q <= bus_in[7];
    end

    assign rise = bus_in[7] & ~strobe_prev_q;

    always_comb begin
        ev.payload = bus_in[VAL_W-1:0];
        if (!rise)          ev.kind = EV_NONE;
        else if (bus_in[6]) ev.kind = EV_ADDR;
        else                ev.kind = EV_DATA;
    end

    // The strobe must drop before another phase can be taken.
    assert_single_edge_R2: assert property (@(posedge clk) disable iff (rst)
        (ev.kind != EV_NONE) |=> (ev.kind == EV_NONE))
        else $error("two phases on consecutive cycles");
endmodule

// File: rtl/nbr_reg_bank.sv
module nbr_reg_bank
    import nbr_pkg::*;
#(
    parameter int NUM_REGS = 56
)(
    input  logic                              clk,
    input  logic                              rst,
    input  bus_ev_t                           ev,
    output logic [VAL_W-1:0]                  rd_val,
    output logic                              wr_pulse,
    output logic [IDX_W-1:0]                  wr_idx,
    output logic [VAL_W-1:0]                  wr_val,
    output logic [NUM_REGS-1:0][VAL_W-1:0]    regs_q
);
    localparam logic [IDX_W:0] NUM_L = (IDX_W+1)'(NUM_REGS);

    logic [IDX_W-1:0] addr_q;
    logic             addr_vld_q;
    logic             addr_mapped;

    assign addr_mapped = addr_vld_q && ({1'b0, addr_q} < NUM_L);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q     <= '0;
            addr_vld_q <= 1'b0;
        end else if (ev.kind == EV_ADDR) begin
            addr_q     <= ev.payload;
            addr_vld_q <= 1'b1;
        end
    end

    assign wr_pulse = (ev.kind == EV_DATA) && addr_mapped;
    assign wr_idx   = addr_q;
    assign wr_val   = ev.payload;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs_q[i] <= '0;
            else if (wr_pulse && (wr_idx == IDX_W'(i)))
                regs_q[i] <= wr_val;
        end
    end

    always_comb begin
        rd_val = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (addr_mapped && (addr_q == IDX_W'(i))) rd_val = regs_q[i];
    end

    assert_write_lands_R4: assert property (@(posedge clk) disable iff (rst)
        wr_pulse |=> (rd_val == $past(wr_val)))
        else $error("written value not read back");

    assert_early_data_dropped_R5: assert property (@(posedge clk) disable iff (rst)
        ((ev.kind == EV_DATA) && !addr_vld_q) |=> $stable(regs_q))
        else $error("value before address changed a register");

    assert_unmapped_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        ((ev.kind == EV_DATA) && addr_vld_q && !addr_mapped) |=> $stable(regs_q))
        else $error("unmapped write changed a register");
endmodule

// File: rtl/nbr_route_table.sv
module nbr_route_table
    import nbr_pkg::*;
#(
    parameter int ROUTE_BASE = 48
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_pulse,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VAL_W-1:0]  wr_val,
    input  logic [VAL_W-1:0]  dst_hi,
    input  logic [VAL_W-1:0]  dst_lo,
    input  logic [VAL_W-1:0]  src_hi,
    input  logic [ID_W-1:0]   sel,
    output logic [ID_W-1:0]   src_out
);
    localparam int N_DST = 1 << ID_W;
    localparam logic [IDX_W-1:0] COMMIT_IDX = IDX_W'(ROUTE_BASE + 3);

    logic [N_DST-1:0][ID_W-1:0] table_q;
    logic                       commit;
    logic [ID_W-1:0]            dst_id;
    logic [ID_W-1:0]            src_id;

    assign commit = wr_pulse && (wr_idx == COMMIT_IDX);
    assign dst_id = make_id(dst_hi, dst_lo);
    assign src_id = make_id(src_hi, wr_val);

    for (genvar d = 0; d < N_DST; d++) begin : g_dst
        always_ff @(posedge clk) begin
            if (rst)
                table_q[d] <= '0;
            else if (commit && (dst_id == ID_W'(d)))
                table_q[d] <= src_id;
        end
    end

    assign src_out = table_q[sel];

    assert_commit_loads_R8: assert property (@(posedge clk) disable iff (rst)
        commit |=> (table_q[$past(dst_id)] == $past(src_id)))
        else $error("route commit missing");

    assert_no_commit_stable_R9: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(table_q))
        else $error("route table changed without commit");
endmodule

// File: rtl/strobed_reg_port.sv
module strobed_reg_port
    import nbr_pkg::*;
#(
    parameter int NUM_REGS       = 56,
    parameter int READ_MASK_BITS = 7,
    parameter int ROUTE_BASE     = 48
)(
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  host_bus,
    input  logic        irq_line,
    output logic [7:0]  upper_byte,
    input  logic [7:0]  route_sel,
    output logic [7:0]  route_src
);
    localparam logic [6:0] RD_MASK = 7'((1 << READ_MASK_BITS) - 1);

    bus_ev_t                        ev;
    logic [VAL_W-1:0]               rd_val;
    logic                           wr_pulse;
    logic [IDX_W-1:0]               wr_idx;
    logic [VAL_W-1:0]               wr_val;
    logic [NUM_REGS-1:0][VAL_W-1:0] regs;

    nbr_strobe_decode u_dec (
        .clk    (clk),
        .rst    (rst),
        .bus_in (host_bus),
        .ev     (ev)
    );

    nbr_reg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .rd_val   (rd_val),
        .wr_pulse (wr_pulse),
        .wr_idx   (wr_idx),
        .wr_val   (wr_val),
        .regs_q   (regs)
    );

    nbr_route_table #(.ROUTE_BASE(ROUTE_BASE)) u_route (
        .clk      (clk),
        .rst      (rst),
        .wr_pulse (wr_pulse),
        .wr_idx   (wr_idx),
        .wr_val   (wr_val),
        .dst_hi   (regs[ROUTE_BASE]),
        .dst_lo   (regs[ROUTE_BASE+1]),
        .src_hi   (regs[ROUTE_BASE+2]),
        .sel      (route_sel),
        .src_out  (route_src)
    );

    always_ff @(posedge clk) begin
        if (rst) upper_byte <= '0;
        else     upper_byte <= {irq_line, {1'b0, rd_val} & RD_MASK};
    end

    assert_irq_mirror_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (upper_byte[7] == $past(irq_line)))
        else $error("interrupt bit not mirrored");

    assert_mask_R6: assert property (@(posedge clk) disable iff (rst)
        ((upper_byte[6:0] & ~RD_MASK) == 7'd0))
        else $error("read data outside mask");
endmodule

// File: tb/sim_strobed_reg_port.sv
module sim_strobed_reg_port;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] host_bus = 8'h00;
    logic       irq_line = 1'b0;
    logic [7:0] upper_byte;
    logic [7:0] route_sel = 8'h00;
    logic [7:0] route_src;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    strobed_reg_port u0 (
        .clk        (clk),
        .rst        (rst),
        .host_bus   (host_bus),
        .irq_line   (irq_line),
        .upper_byte (upper_byte),
        .route_sel  (route_sel),
        .route_src  (route_src)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic phase(input logic [6:0] v);
        @(negedge clk) host_bus = {1'b0, v};
        repeat (3) @(negedge clk);
        host_bus = {1'b1, v};
        repeat (3) @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] idx, input logic [5:0] val);
        phase({1'b1, idx});
        phase({1'b0, val});
    endtask

    task automatic rd(input logic [5:0] idx, output logic [6:0] val);
        phase({1'b1, idx});
        val = upper_byte[6:0];
    endtask

    task automatic look(input logic [7:0] sel, output logic [7:0] src);
        @(negedge clk) route_sel = sel;
        @(negedge clk) src = route_src;
    endtask

    task automatic t_reset;
        logic [7:0] s;
        chk("R1 upper_byte", upper_byte, 8'h00);
        look(8'h00, s); chk("R1 route 0x00", s, 8'h00);
        look(8'hFF, s); chk("R1 route 0xFF", s, 8'h00);
    endtask

    task automatic t_early_data;
        logic [6:0] v;
        phase(7'h15);
        rd(6'd0, v); chk("R5 idx0", {1'b0, v}, 8'h00);
        rd(6'd5, v); chk("R5 idx5", {1'b0, v}, 8'h00);
    endtask

    task automatic t_write_read;
        logic [6:0] v;
        wr(6'd0, 6'h2A); wr(6'd55, 6'h3F); wr(6'd10, 6'h11);
        rd(6'd0, v);  chk("R3 idx0", {1'b0, v}, 8'h2A);
        rd(6'd55, v); chk("R3 idx55", {1'b0, v}, 8'h3F);
        rd(6'd10, v); chk("R3 idx10", {1'b0, v}, 8'h11);
        phase(7'h4C); phase(7'h01); phase(7'h22);
        chk("R4 repeated value same addr", {1'b0, upper_byte[6:0]}, 8'h22);
        rd(6'd0, v); chk("R4 other reg untouched", {1'b0, v}, 8'h2A);
    endtask

    task automatic t_strobe_edges;
        logic [6:0] v;
        rd(6'd10, v);
        @(negedge clk) host_bus = 8'h43;
        repeat (5) @(negedge clk);
        chk("R2 strobe-low addr ignored", {1'b0, upper_byte[6:0]}, 8'h11);
        host_bus = 8'hA0;
        repeat (3) @(negedge clk);
        host_bus = 8'h85;
        repeat (4) @(negedge clk);
        chk("R2 change while high ignored", {1'b0, upper_byte[6:0]}, 8'h20);
        host_bus = 8'h05;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_irq;
        logic [6:0] v;
        rd(6'd55, v);
        @(negedge clk) irq_line = 1'b1;
        repeat (2) @(negedge clk);
        chk("R6 irq bit with data", upper_byte, 8'hBF);
        irq_line = 1'b0;
        repeat (2) @(negedge clk);
        chk("R6 irq bit cleared", upper_byte, 8'h3F);
    endtask

    task automatic t_unmapped;
        logic [6:0] v;
        wr(6'd60, 6'h2C);
        rd(6'd60, v); chk("R7 unmapped read", {1'b0, v}, 8'h00);
        rd(6'd4, v);  chk("R7 alias untouched", {1'b0, v}, 8'h00);
    endtask

    task automatic t_route;
        logic [7:0] s;
        wr(6'h30, 6'h0D); wr(6'h31, 6'h3A); wr(6'h32, 6'h02);
        look(8'hBA, s); chk("R9 no commit before src low", s, 8'h00);
        wr(6'h33, 6'h07);
        look(8'hBA, s); chk("R8 commit masked ids", s, 8'h47);
        wr(6'h31, 6'h01); wr(6'h33, 6'h07);
        look(8'hA1, s); chk("R10 second dest", s, 8'h47);
        look(8'hBA, s); chk("R10 first dest kept", s, 8'h47);
        wr(6'h31, 6'h1A); wr(6'h32, 6'h03); wr(6'h33, 6'h04);
        look(8'hBA, s); chk("R10 dest replaced", s, 8'h64);
        look(8'hA1, s); chk("R11 other dest lookup", s, 8'h47);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_early_data;
        t_write_read;
        t_strobe_edges;
        t_irq;
        t_unmapped;
        t_route;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule